// File: doc/BRIEF.md
# Idle-Gap Address-Marking Serial Transmitter

This block is an asynchronous serial transmitter for multiprocessor links where blocks of characters are separated by idle time on the line, and the first character after such a gap is read as an address. Software writes a character into a single holding buffer together with a one-bit address-mark request. The buffer hands both to the shift stage as a pair. A character that carries the request is sent only after the transmitter has driven the line high for exactly eleven bit periods. A character without the request follows the previous frame with no idle time between them.

The bit period is `cfg_div + 1` clock cycles and comes from an internal divider. A frame is a low start bit, the data bits LSB first, an optional parity bit (even or odd), and one or two high stop bits. The holding buffer frees as soon as its contents move to the shift stage. Software can therefore queue the next character while the current one is still in its idle gap.

The sequencer has six states:
- `ST_IDLE`: the line is high and the divider is stopped.
- `ST_GAP`: eleven high bit periods.
- `ST_START`, `ST_DATA`, `ST_PARITY`, `ST_STOP`: one state for each part of the frame.

The sequencer has these transitions:
- *load*: from `ST_IDLE`, or from the end of the last stop bit, into `ST_GAP` if the character is marked, otherwise into `ST_START`.
- *gap_done*: from `ST_GAP` to `ST_START`.
- *start_done*: from `ST_START` to `ST_DATA`.
- *data_done*: from `ST_DATA` to `ST_PARITY`, or to `ST_STOP` when parity is off.
- *parity_done*: from `ST_PARITY` to `ST_STOP`.
- *drain*: from `ST_STOP` to `ST_IDLE` when the buffer is empty.

Top module: `idle_gap_uart_tx`

## Requirements
- R1: After reset `txd` is 1 and `tx_buf_empty` is 1.
- R2: A frame starts with one low start bit, followed by `DATA_W` data bits LSB first. Each bit lasts `cfg_div + 1` clock cycles.
- R3: When `cfg_parity_en` is 1, one parity bit follows the data. With `cfg_parity_odd` = 0 it equals the XOR of the data bits. With `cfg_parity_odd` = 1 it is the inverse of that XOR.
- R4: The frame ends with one high stop bit, or two when `cfg_two_stop` is 1.
- R5: A character without the mark request that is already in the buffer when the last stop bit ends starts its start bit on the very next bit period. No idle time is inserted.
- R6: A character with the mark request is preceded by exactly 11 high bit periods. These follow directly after the previous stop bits. When the transmitter was idle, the start bit falls 2 + 11 × (`cfg_div` + 1) cycles after the write cycle.
- R7: The mark request is stored with its character. A character written during another character's gap gets its own gap only if its own request is set. The request is cleared by the time the start bit is driven.
- R8: `tx_buf_empty` falls in the cycle after an accepted write. It rises in the cycle after the buffer moves into the shift stage, including when that move opens an idle gap.
- R9: A write while `tx_buf_empty` is 0 is dropped: the buffered character and its mark are unchanged, and no extra frame is sent.
- R10: When the transmitter is idle, an unmarked character's start bit falls 2 cycles after its write cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_div | input | DIV_W | Bit period minus one, in clock cycles |
| cfg_parity_en | input | 1 | Append a parity bit |
| cfg_parity_odd | input | 1 | 1 = odd parity, 0 = even parity |
| cfg_two_stop | input | 1 | 1 = two stop bits |
| tx_wr | input | 1 | Write strobe for the holding buffer |
| tx_data | input | DATA_W | Character to send |
| tx_addr_mark | input | 1 | Precede this character with an 11-bit idle gap |
| tx_buf_empty | output | 1 | Holding buffer can accept a write |
| txd | output | 1 | Serial line, idles high |

## Verification
The bench measures the high time between the end of one frame's data or parity bit and the next start edge. A sequencer that added a bit of idle between unmarked characters would fail that check, and so would one that counted the gap one period short or long, or counted it in clock cycles instead of bit periods. It writes a marked character during one character's gap and an unmarked one during another's. A mark that leaked from the shift stage back to the buffer, or that was not cleared at the start bit, would gap the wrong character. It also writes into a full buffer: an overwrite would change the decoded data, and a queued phantom write would show up as an extra frame. Parity is checked in both senses and with both stop counts, at two divisor settings.

// File: rtl/uatx_pkg.sv
package uatx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_GAP,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP
    } tx_state_e;

endpackage

// File: rtl/uatx_baud.sv
module uatx_baud #(
    parameter int unsigned DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);

    logic [DIV_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || cnt_q == div) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign tick = run && (cnt_q == div);

    // R2
    tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && div != '0) |=> !tick);

endmodule

// File: rtl/uatx_holdbuf.sv
module uatx_holdbuf #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_mark,
    input  logic              take,
    output logic              full,
    output logic [DATA_W-1:0] data,
    output logic              mark
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            full <= 1'b0;
            data <= '0;
            mark <= 1'b0;
        end else if (take) begin
            full <= 1'b0;
        end else if (wr_en && !full) begin
            full <= 1'b1;
            data <= wr_data;
            mark <= wr_mark;
        end
    end

    // R8
    fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !full) |=> full);

    // R9
    drop_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && full && !take) |=> ($stable(data) && $stable(mark)));

endmodule

// File: rtl/uatx_frame.sv
module uatx_frame
    import uatx_pkg::*;
#(
    parameter int unsigned DATA_W   = 8,
    parameter int unsigned GAP_BITS = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              hold_full,
    input  logic [DATA_W-1:0] hold_data,
    input  logic              hold_mark,
    input  logic              par_en,
    input  logic              par_odd,
    input  logic              two_stop,
    output logic              take,
    output logic              baud_run,
    output logic              txd
);

    localparam int unsigned CNT_MAX = (DATA_W > GAP_BITS) ? DATA_W : GAP_BITS;
    localparam int unsigned CNT_W   = $clog2(CNT_MAX + 1);
    localparam logic [CNT_W-1:0] GAP_LAST  = CNT_W'(GAP_BITS - 1);
    localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(DATA_W - 1);
    localparam logic [CNT_W-1:0] STOP2     = CNT_W'(1);

    tx_state_e         state_q, state_d;
    logic [DATA_W-1:0] shreg_q, shreg_d;
    logic              mark_q, mark_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d;
    logic              par_q, par_d;
    logic              load_ok;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            shreg_q <= '0;
            mark_q  <= 1'b0;
            cnt_q   <= '0;
            par_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            shreg_q <= shreg_d;
            mark_q  <= mark_d;
            cnt_q   <= cnt_d;
            par_q   <= par_d;
        end
    end

    always_comb begin
        state_d = state_q;
        shreg_d = shreg_q;
        mark_d  = mark_q;
        cnt_d   = cnt_q;
        par_d   = par_q;
        load_ok = 1'b0;
        unique case (state_q)
            ST_IDLE: load_ok = hold_full;
            ST_GAP: if (tick) begin
                if (cnt_q == GAP_LAST) begin
                    state_d = ST_START;
                    mark_d  = 1'b0;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            ST_START: if (tick) begin
                state_d = ST_DATA;
                cnt_d   = '0;
            end
            ST_DATA: if (tick) begin
                shreg_d = shreg_q >> 1;
                par_d   = par_q ^ shreg_q[0];
                if (cnt_q == DATA_LAST) begin
                    state_d = par_en ? ST_PARITY : ST_STOP;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            ST_PARITY: if (tick) begin
                state_d = ST_STOP;
                cnt_d   = '0;
            end
            ST_STOP: if (tick) begin
                if (!two_stop || cnt_q == STOP2) begin
                    if (hold_full) load_ok = 1'b1;
                    else           state_d = ST_IDLE;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
        if (load_ok) begin
            shreg_d = hold_data;
            mark_d  = hold_mark;
            par_d   = 1'b0;
            cnt_d   = '0;
            state_d = hold_mark ? ST_GAP : ST_START;
        end
        take = load_ok;
    end

    always_comb begin
        baud_run = (state_q != ST_IDLE);
        unique case (state_q)
            ST_START:  txd = 1'b0;
            ST_DATA:   txd = shreg_q[0];
            ST_PARITY: txd = par_q ^ par_odd;
            default:   txd = 1'b1;
        endcase
    end

    // R6
    gap_count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_GAP) |-> (cnt_q <= GAP_LAST));

    // R7
    mark_cleared_at_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_START) |-> !mark_q);

    // R2
    start_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(txd) |-> (state_q == ST_START || state_q == ST_DATA || state_q == ST_PARITY));

    // R8
    take_needs_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> hold_full);

endmodule

// File: rtl/idle_gap_uart_tx.sv
module idle_gap_uart_tx #(
    parameter int unsigned DATA_W   = 8,
    parameter int unsigned DIV_W    = 16,
    parameter int unsigned GAP_BITS = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIV_W-1:0]  cfg_div,
    input  logic              cfg_parity_en,
    input  logic              cfg_parity_odd,
    input  logic              cfg_two_stop,
    input  logic              tx_wr,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              tx_addr_mark,
    output logic              tx_buf_empty,
    output logic              txd
);

    logic              tick;
    logic              baud_run;
    logic              take;
    logic              hold_full;
    logic [DATA_W-1:0] hold_data;
    logic              hold_mark;

    uatx_baud #(.DIV_W(DIV_W)) u_baud (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (baud_run),
        .div  (cfg_div),
        .tick (tick)
    );

    uatx_holdbuf #(.DATA_W(DATA_W)) u_hold (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (tx_wr),
        .wr_data(tx_data),
        .wr_mark(tx_addr_mark),
        .take   (take),
        .full   (hold_full),
        .data   (hold_data),
        .mark   (hold_mark)
    );

    uatx_frame #(.DATA_W(DATA_W), .GAP_BITS(GAP_BITS)) u_frame (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .hold_full(hold_full),
        .hold_data(hold_data),
        .hold_mark(hold_mark),
        .par_en   (cfg_parity_en),
        .par_odd  (cfg_parity_odd),
        .two_stop (cfg_two_stop),
        .take     (take),
        .baud_run (baud_run),
        .txd      (txd)
    );

    assign tx_buf_empty = !hold_full;

    // R1
    idle_line_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!baud_run) |-> txd);

endmodule

// File: tb/idle_gap_uart_tx_test.sv
module idle_gap_uart_tx_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] cfg_div;
    logic        cfg_parity_en, cfg_parity_odd, cfg_two_stop;
    logic        tx_wr;
    logic [7:0]  tx_data;
    logic        tx_addr_mark;
    logic        tx_buf_empty, txd;

    int n_chk = 0;
    int n_err = 0;
    int cyc = 0;
    int pushed = 0;
    int frames = 0;
    bit finished = 0;

    typedef struct {
        logic [7:0] data;
        bit         mark;
        int         exp_start;
        int         exp_run;
    } exp_t;
    exp_t sb[$];

    idle_gap_uart_tx uut (
        .clk(clk), .rst_n(rst_n), .cfg_div(cfg_div),
        .cfg_parity_en(cfg_parity_en), .cfg_parity_odd(cfg_parity_odd),
        .cfg_two_stop(cfg_two_stop), .tx_wr(tx_wr), .tx_data(tx_data),
        .tx_addr_mark(tx_addr_mark), .tx_buf_empty(tx_buf_empty), .txd(txd)
    );

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic int per();
        return int'(cfg_div) + 1;
    endfunction

    function automatic int nstop();
        return cfg_two_stop ? 2 : 1;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic send_idle(input logic [7:0] d, input bit m);
        exp_t it;
        int w;
        @(negedge clk);
        tx_wr = 1'b1; tx_data = d; tx_addr_mark = m;
        w = cyc;
        it.data = d; it.mark = m; it.exp_run = -1;
        it.exp_start = w + 2 + (m ? 11 * per() : 0);
        sb.push_back(it); pushed++;
        @(negedge clk);
        tx_wr = 1'b0;
        check(tx_buf_empty == 1'b0, "R8", "empty after write", int'(tx_buf_empty), 0);
        @(negedge clk);
        check(tx_buf_empty == 1'b1, "R8", "empty after transfer", int'(tx_buf_empty), 1);
    endtask

    task automatic send_b2b(input logic [7:0] d, input bit m);
        exp_t it;
        @(negedge clk);
        while (!tx_buf_empty) @(negedge clk);
        tx_wr = 1'b1; tx_data = d; tx_addr_mark = m;
        it.data = d; it.mark = m; it.exp_start = -1;
        it.exp_run = (nstop() + (m ? 11 : 0)) * per();
        sb.push_back(it); pushed++;
        @(negedge clk);
        tx_wr = 1'b0;
    endtask

    task automatic drop_write(input logic [7:0] d);
        check(tx_buf_empty == 1'b0, "R9", "buffer full before extra write", int'(tx_buf_empty), 0);
        tx_wr = 1'b1; tx_data = d; tx_addr_mark = 1'b1;
        @(negedge clk);
        tx_wr = 1'b0;
        check(tx_buf_empty == 1'b0, "R9", "buffer still full", int'(tx_buf_empty), 0);
    endtask

    task automatic wait_done();
        while (frames != pushed) @(negedge clk);
        repeat (4 * per()) @(negedge clk);
    endtask

    // Monitor: decodes each frame on txd and compares with the scoreboard
    initial begin
        int s;
        int last_end;
        int p;
        int npar;
        exp_t it;
        logic [7:0] got;
        logic pbit, expp;
        last_end = -1;
        forever begin
            @(negedge clk);
            if (rst_n === 1'b1 && txd === 1'b0) begin
                s = cyc;
                p = per();
                npar = cfg_parity_en ? 1 : 0;
                if (sb.size() == 0) begin
                    check(1'b0, "R9", "unexpected frame", 1, 0);
                    it.data = 8'h00; it.mark = 1'b0; it.exp_start = -1; it.exp_run = -1;
                end else begin
                    it = sb.pop_front();
                end
                if (it.exp_start >= 0)
                    check(s == it.exp_start, it.mark ? "R6" : "R10", "start cycle", s, it.exp_start);
                if (it.exp_run >= 0 && last_end >= 0)
                    check(s - last_end == it.exp_run, it.mark ? "R6" : "R5",
                          "high time before start", s - last_end, it.exp_run);
                repeat (p / 2) @(negedge clk);
                check(txd == 1'b0, "R2", "start bit", int'(txd), 0);
                for (int j = 0; j < 8; j++) begin
                    repeat (p) @(negedge clk);
                    got[j] = txd;
                end
                check(got == it.data, it.mark ? "R7" : "R2", "data", int'(got), int'(it.data));
                if (npar == 1) begin
                    repeat (p) @(negedge clk);
                    pbit = txd;
                    expp = cfg_parity_odd ? ~(^it.data) : (^it.data);
                    check(pbit == expp, "R3", "parity bit", int'(pbit), int'(expp));
                end
                for (int k = 0; k < nstop(); k++) begin
                    repeat (p) @(negedge clk);
                    check(txd == 1'b1, "R4", "stop bit", int'(txd), 1);
                end
                last_end = s + (9 + npar) * p;
                frames++;
            end
        end
    end

    initial begin
        #1_000_000;
        if (!finished) begin
            n_err++;
            $display("FAIL R2 watchdog: actual hung expected done");
            $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        tx_wr = 1'b0; tx_data = 8'h00; tx_addr_mark = 1'b0;
        cfg_div = 16'd3; cfg_parity_en = 1'b0; cfg_parity_odd = 1'b0; cfg_two_stop = 1'b0;
        repeat (5) @(negedge clk);
        check(txd == 1'b1, "R1", "txd in reset", int'(txd), 1);
        check(tx_buf_empty == 1'b1, "R1", "empty in reset", int'(tx_buf_empty), 1);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(txd == 1'b1, "R1", "txd after reset", int'(txd), 1);
        check(tx_buf_empty == 1'b1, "R1", "empty after reset", int'(tx_buf_empty), 1);

        // 4-cycle bits, no parity, one stop
        send_idle(8'h55, 1'b1);
        send_b2b(8'hA3, 1'b0);      // R7: unmarked, loaded during a gap
        drop_write(8'h99);          // R9
        send_b2b(8'h0F, 1'b1);
        send_b2b(8'hF0, 1'b0);
        wait_done();

        // 8-cycle bits, even parity, two stops
        cfg_div = 16'd7; cfg_parity_en = 1'b1; cfg_parity_odd = 1'b0; cfg_two_stop = 1'b1;
        send_idle(8'h81, 1'b1);
        send_b2b(8'h7E, 1'b1);      // R7: marked, loaded during a gap
        send_b2b(8'h00, 1'b0);
        send_b2b(8'hB5, 1'b0);
        wait_done();

        // 4-cycle bits, odd parity, one stop
        cfg_div = 16'd3; cfg_parity_en = 1'b1; cfg_parity_odd = 1'b1; cfg_two_stop = 1'b0;
        send_idle(8'h3C, 1'b0);     // R10
        send_b2b(8'hC3, 1'b0);
        send_b2b(8'h5A, 1'b1);
        send_b2b(8'h01, 1'b0);
        wait_done();

        repeat (200) @(negedge clk);
        check(frames == pushed, "R9", "frame count", frames, pushed);
        check(sb.size() == 0, "R9", "scoreboard left over", sb.size(), 0);
        check(txd == 1'b1, "R1", "line idle at end", int'(txd), 1);
        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule